// File: doc/BRIEF.md
# DAC Power and Reference Controller

This block is the command-side control logic for an eight-channel voltage-output converter. A serial front end (outside this block) delivers a decoded frame as a 4-bit opcode, a 4-bit channel address and a 16-bit code, qualified by a one-cycle strobe. A separate single-cycle load pulse, already synchronised to the clock, copies every input register into its DAC register.

The block holds the per-channel input and DAC registers. It also tracks which output amplifiers are powered, whether the on-chip reference runs, and which reference source is selected. A settling flag is raised whenever a powered-down channel comes back up. How long the flag stays high depends on how deeply the device had been shut down.

Whether the on-chip reference may come back depends on how it went off. If it was turned off by choosing the external source, only an explicit select-internal opcode brings it back. If it was turned off by a whole-chip shutdown, any wake-up of a channel brings it back.

Top module: `dacpwr_ctrl`

## Requirements
- R1: After reset all channels are powered, the input and DAC registers are zero, busy is low, `ref_ext_sel` equals the parameter `EXT_REF_DEFAULT` (default 0), and `ref_int_en` is its inverse.
- R2: Opcode 0000 writes `data` into the input register of the addressed channel and leaves the DAC registers alone. Address 1111 selects all channels, and addresses 8 to 14 select none.
- R3: Opcode 0001 copies the input register to the DAC register of the addressed channel(s). Opcode 0011 writes and then copies the addressed channel(s). Opcode 0010 writes the addressed channel(s) and then copies every channel.
- R4: A load pulse copies every input register (including one written in the same cycle) into its DAC register.
- R5: Opcode 0100 clears the power enable of the addressed channel(s) only. The `data` word is ignored, and no input or DAC register changes.
- R6: Opcode 0101 clears every channel's power enable and turns the internal reference off. The `data` word is ignored.
- R7: Opcodes 0001, 0010 and 0011 and the load pulse set the power enable of every channel they update. Such a power-up takes priority over a power-down in the same cycle.
- R8: Opcode 0111 sets `ref_ext_sel` and turns the internal reference off. While the external source stays selected, the internal reference stays off until opcode 0110 clears `ref_ext_sel` and turns it back on.
- R9: After opcode 0101, any channel power-up (opcode or load pulse) also turns the internal reference back on, unless the external source is selected.
- R10: When at least one channel goes from off to on, busy rises on the next cycle and stays high for exactly SHORT cycles (CLK_HZ × 10 µs). It stays high for LONG cycles (CLK_HZ × 12 µs) instead if, before that update, every channel was off and the internal reference was off. A further wake-up restarts the count.
- R11: `ref_hiz` is high exactly when the internal reference is off and no channel is powered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_vld | input | 1 | One-cycle strobe qualifying opcode, address and code |
| cmd | input | 4 | Opcode |
| addr | input | 4 | Channel address, 1111 = all |
| data | input | DW | Conversion code |
| load_pulse | input | 1 | Synchronised load pulse: update and power up all channels |
| ch_pwr_en | output | NCH | Per-channel amplifier power enable |
| ref_int_en | output | 1 | Internal reference running |
| ref_ext_sel | output | 1 | External reference source selected |
| ref_hiz | output | 1 | Reference pin to be left high impedance |
| busy | output | 1 | Power-up settling in progress |
| inp_q | output | NCH*DW | Input registers, channel 0 in the low bits |
| dac_q | output | NCH*DW | DAC registers, channel 0 in the low bits |

## Verification
Directed sequences first take a single channel down and back up, which yields the short settle window. They then shut the whole chip down with the external source selected and recover it, which yields the long window while the reference stays locked off. A third sequence shuts the chip down with the internal source selected and recovers it, which shows the reference returning on wake-up. Seeded random opcodes, addresses and codes follow, with occasional load pulses. They mix power-down with updates in the same cycle, use the all-channel and unused addresses, and mix the two reference opcodes. This shows whether priority, register retention and the restart of the settle count hold up in arbitrary orders. Every output is compared each cycle against a bench model.

// File: rtl/dacpwr_pkg.sv
package dacpwr_pkg;

  typedef enum logic [3:0] {
    OP_WR_IN      = 4'b0000,
    OP_UPD        = 4'b0001,
    OP_WR_UPD_ALL = 4'b0010,
    OP_WR_UPD     = 4'b0011,
    OP_PD_CH      = 4'b0100,
    OP_PD_CHIP    = 4'b0101,
    OP_REF_INT    = 4'b0110,
    OP_REF_EXT    = 4'b0111
  } op_e;

  localparam logic [3:0] ADDR_ALL = 4'hF;

endpackage

// File: rtl/dacpwr_decode.sv
module dacpwr_decode
  import dacpwr_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic           cmd_vld,
  input  logic [3:0]     cmd,
  input  logic [3:0]     addr,
  input  logic           load_pulse,
  output logic [NCH-1:0] wr_mask,
  output logic [NCH-1:0] upd_mask,
  output logic [NCH-1:0] pd_mask,
  output logic           pd_chip,
  output logic           sel_int,
  output logic           sel_ext
);

  logic [NCH-1:0] amask;
  op_e            op;

  assign op = op_e'(cmd);

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      amask[i] = (addr == ADDR_ALL) || (addr == 4'(i));
    end
  end

  always_comb begin
    wr_mask  = '0;
    upd_mask = '0;
    pd_mask  = '0;
    pd_chip  = 1'b0;
    sel_int  = 1'b0;
    sel_ext  = 1'b0;
    if (cmd_vld) begin
      unique case (op)
        OP_WR_IN:      wr_mask = amask;
        OP_UPD:        upd_mask = amask;
        OP_WR_UPD_ALL: begin wr_mask = amask; upd_mask = '1; end
        OP_WR_UPD:     begin wr_mask = amask; upd_mask = amask; end
        OP_PD_CH:      pd_mask = amask;
        OP_PD_CHIP:    begin pd_mask = '1; pd_chip = 1'b1; end
        OP_REF_INT:    sel_int = 1'b1;
        OP_REF_EXT:    sel_ext = 1'b1;
        default:       ;
      endcase
    end
    if (load_pulse) upd_mask = '1;
  end

endmodule

// File: rtl/dacpwr_regs.sv
module dacpwr_regs #(
  parameter int NCH = 8,
  parameter int DW  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    wr_mask,
  input  logic [NCH-1:0]    upd_mask,
  input  logic [DW-1:0]     data,
  output logic [NCH*DW-1:0] inp_q,
  output logic [NCH*DW-1:0] dac_q
);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [DW-1:0] inp_r, dac_r, inp_d, dac_d;

    always_comb begin
      inp_d = wr_mask[g] ? data : inp_r;
      dac_d = inp_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        inp_r <= '0;
      end else if (wr_mask[g]) begin
        inp_r <= inp_d;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dac_r <= '0;
      end else if (upd_mask[g]) begin
        dac_r <= dac_d;
      end
    end

    assign inp_q[g*DW +: DW] = inp_r;
    assign dac_q[g*DW +: DW] = dac_r;
  end

endmodule

// File: rtl/dacpwr_settle.sv
module dacpwr_settle #(
  parameter int SHORT_CYC = 500,
  parameter int LONG_CYC  = 600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wake,
  input  logic deep,
  output logic busy
);

  localparam int CW = $clog2(LONG_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = wake || (cnt_q != '0);
    if (wake) begin
      cnt_d = deep ? CW'(LONG_CYC) : CW'(SHORT_CYC);
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign busy = (cnt_q != '0);

endmodule

// File: rtl/dacpwr_ctrl.sv
module dacpwr_ctrl #(
  parameter int NCH             = 8,
  parameter int DW              = 16,
  parameter int CLK_HZ          = 50_000_000,
  parameter int SHORT_NS        = 10_000,
  parameter int LONG_NS         = 12_000,
  parameter bit EXT_REF_DEFAULT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_vld,
  input  logic [3:0]        cmd,
  input  logic [3:0]        addr,
  input  logic [DW-1:0]     data,
  input  logic              load_pulse,
  output logic [NCH-1:0]    ch_pwr_en,
  output logic              ref_int_en,
  output logic              ref_ext_sel,
  output logic              ref_hiz,
  output logic              busy,
  output logic [NCH*DW-1:0] inp_q,
  output logic [NCH*DW-1:0] dac_q
);

  localparam int KHZ       = CLK_HZ / 1000;
  localparam int SHORT_CYC = (KHZ * SHORT_NS) / 1_000_000;
  localparam int LONG_CYC  = (KHZ * LONG_NS) / 1_000_000;

  logic [1:0]     rst_sync;
  logic           rst_sync_n;
  logic [NCH-1:0] wr_mask, upd_mask, pd_mask;
  logic           pd_chip, sel_int, sel_ext;
  logic [NCH-1:0] pwr_q, pwr_d;
  logic           ext_q, ext_d, chip_q, chip_d;
  logic           state_en, wake, deep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sync_n = rst_sync[1];

  dacpwr_decode #(.NCH(NCH)) u_dec (
    .cmd_vld(cmd_vld), .cmd(cmd), .addr(addr), .load_pulse(load_pulse),
    .wr_mask(wr_mask), .upd_mask(upd_mask), .pd_mask(pd_mask),
    .pd_chip(pd_chip), .sel_int(sel_int), .sel_ext(sel_ext)
  );

  dacpwr_regs #(.NCH(NCH), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_mask(wr_mask), .upd_mask(upd_mask),
    .data(data), .inp_q(inp_q), .dac_q(dac_q)
  );

  always_comb begin
    state_en = cmd_vld || load_pulse;
    wake     = |(upd_mask & ~pwr_q);
    deep     = (pwr_q == '0) && !ref_int_en;
    pwr_d    = (pwr_q & ~pd_mask) | upd_mask;
    ext_d    = ext_q;
    if (sel_int)      ext_d = 1'b0;
    else if (sel_ext) ext_d = 1'b1;
    chip_d   = chip_q;
    if (sel_int || (upd_mask != '0)) chip_d = 1'b0;
    else if (pd_chip)                chip_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pwr_q  <= '1;
      ext_q  <= EXT_REF_DEFAULT;
      chip_q <= 1'b0;
    end else if (state_en) begin
      pwr_q  <= pwr_d;
      ext_q  <= ext_d;
      chip_q <= chip_d;
    end
  end

  dacpwr_settle #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_settle (
    .clk(clk), .rst_n(rst_sync_n), .wake(wake), .deep(deep), .busy(busy)
  );

  assign ch_pwr_en   = pwr_q;
  assign ref_ext_sel = ext_q;
  assign ref_int_en  = !ext_q && !chip_q;
  assign ref_hiz     = !ref_int_en && (pwr_q == '0);

endmodule

// File: rtl/dacpwr_ctrl_chk.sv
module dacpwr_ctrl_chk #(
  parameter int NCH = 8,
  parameter int DW  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_vld,
  input logic [3:0]        cmd,
  input logic [3:0]        addr,
  input logic              load_pulse,
  input logic [NCH-1:0]    ch_pwr_en,
  input logic              ref_int_en,
  input logic              ref_ext_sel,
  input logic              ref_hiz,
  input logic              busy,
  input logic [NCH*DW-1:0] inp_q,
  input logic [NCH*DW-1:0] dac_q
);

  p_ldac_all_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_pulse |=> (ch_pwr_en == {NCH{1'b1}}));

  p_pd_keeps_regs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && cmd == 4'b0100 && !load_pulse) |=> ($stable(inp_q) && $stable(dac_q)));

  p_chip_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && cmd == 4'b0101 && !load_pulse) |=> (ch_pwr_en == '0 && !ref_int_en));

  p_upd_all_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && cmd == 4'b0011 && addr == 4'hF) |=> (ch_pwr_en == {NCH{1'b1}}));

  p_ext_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_ext_sel && !(cmd_vld && cmd == 4'b0110)) |=> !ref_int_en);

  p_wake_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (load_pulse && ch_pwr_en != {NCH{1'b1}}) |=> busy);

  p_hiz_after_chip_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && cmd == 4'b0101 && !load_pulse) |=> ref_hiz);

endmodule

bind dacpwr_ctrl dacpwr_ctrl_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .cmd_vld(cmd_vld), .cmd(cmd), .addr(addr),
  .load_pulse(load_pulse), .ch_pwr_en(ch_pwr_en), .ref_int_en(ref_int_en),
  .ref_ext_sel(ref_ext_sel), .ref_hiz(ref_hiz), .busy(busy),
  .inp_q(inp_q), .dac_q(dac_q)
);

// File: tb/dacpwr_ctrl_bench.sv
module dacpwr_ctrl_bench;

  localparam int NCH   = 8;
  localparam int DW    = 16;
  localparam int SHORT = 500;
  localparam int LONG  = 600;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cmd_vld;
  logic [3:0]        cmd, addr;
  logic [DW-1:0]     data;
  logic              load_pulse;
  logic [NCH-1:0]    ch_pwr_en;
  logic              ref_int_en, ref_ext_sel, ref_hiz, busy;
  logic [NCH*DW-1:0] inp_q, dac_q;

  int checks = 0;
  int errors = 0;

  logic [DW-1:0]  m_inp [NCH];
  logic [DW-1:0]  m_dac [NCH];
  logic [NCH-1:0] m_pwr;
  logic           m_ext, m_chip;
  int             m_cnt;

  always #10 clk = ~clk;

  dacpwr_ctrl u_dacpwr_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd(cmd), .addr(addr),
    .data(data), .load_pulse(load_pulse), .ch_pwr_en(ch_pwr_en),
    .ref_int_en(ref_int_en), .ref_ext_sel(ref_ext_sel), .ref_hiz(ref_hiz),
    .busy(busy), .inp_q(inp_q), .dac_q(dac_q)
  );

  function automatic logic m_ref_on();
    return !m_ext && !m_chip;
  endfunction

  function automatic logic [NCH-1:0] amask(input logic [3:0] a);
    logic [NCH-1:0] m = '0;
    for (int i = 0; i < NCH; i++) if (a == 4'hF || a == 4'(i)) m[i] = 1'b1;
    return m;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model(input logic v, input logic [3:0] c, input logic [3:0] a,
                       input logic [DW-1:0] d, input logic l);
    logic [NCH-1:0] m = amask(a);
    logic [NCH-1:0] wr = '0, up = '0, pd = '0;
    if (v) begin
      case (c)
        4'd0: wr = m;
        4'd1: up = m;
        4'd2: begin wr = m; up = '1; end
        4'd3: begin wr = m; up = m; end
        4'd4: pd = m;
        4'd5: pd = '1;
        default: ;
      endcase
    end
    if (l) up = '1;
    for (int i = 0; i < NCH; i++) begin
      if (wr[i]) m_inp[i] = d;
      if (up[i]) m_dac[i] = m_inp[i];
    end
    if ((up & ~m_pwr) != '0) m_cnt = (m_pwr == '0 && !m_ref_on()) ? LONG : SHORT;
    else if (m_cnt > 0) m_cnt--;
    m_pwr = (m_pwr & ~pd) | up;
    if (v && c == 4'd6) begin m_ext = 1'b0; m_chip = 1'b0; end
    else begin
      if (v && c == 4'd7) m_ext = 1'b1;
      if (up != '0) m_chip = 1'b0;
      else if (v && c == 4'd5) m_chip = 1'b1;
    end
  endtask

  task automatic compare_all();
    chk(ch_pwr_en == m_pwr, "R7 power enables", ch_pwr_en, m_pwr);
    chk(ref_int_en == m_ref_on(), "R8 internal ref", ref_int_en, m_ref_on());
    chk(ref_ext_sel == m_ext, "R8 ref select", ref_ext_sel, m_ext);
    chk(ref_hiz == (!m_ref_on() && m_pwr == '0), "R11 ref hiz", ref_hiz,
        (!m_ref_on() && m_pwr == '0));
    chk(busy == (m_cnt != 0), "R10 busy", busy, (m_cnt != 0));
    for (int i = 0; i < NCH; i++) begin
      chk(inp_q[i*DW +: DW] == m_inp[i], "R2 input reg", inp_q[i*DW +: DW], m_inp[i]);
      chk(dac_q[i*DW +: DW] == m_dac[i], "R3 DAC reg", dac_q[i*DW +: DW], m_dac[i]);
    end
  endtask

  task automatic step(input logic v, input logic [3:0] c, input logic [3:0] a,
                      input logic [DW-1:0] d, input logic l);
    cmd_vld = v; cmd = c; addr = a; data = d; load_pulse = l;
    @(posedge clk);
    model(v, c, a, d, l);
    @(negedge clk);
    cmd_vld = 1'b0; load_pulse = 1'b0;
    compare_all();
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy && n < 2000) begin
      n++;
      step(1'b0, 4'd0, 4'd0, '0, 1'b0);
    end
  endtask

  initial begin
    #(20 * 150_000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    int unsigned r;
    rst_n = 1'b0; cmd_vld = 1'b0; cmd = '0; addr = '0; data = '0; load_pulse = 1'b0;
    for (int i = 0; i < NCH; i++) begin m_inp[i] = '0; m_dac[i] = '0; end
    m_pwr = '1; m_ext = 1'b0; m_chip = 1'b0; m_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(ch_pwr_en == '1 && !busy, "R1 power/busy", {ch_pwr_en, busy}, {8'hFF, 1'b0});
    chk(ref_int_en && !ref_ext_sel && !ref_hiz, "R1 reference",
        {ref_int_en, ref_ext_sel, ref_hiz}, 3'b100);
    chk(inp_q == '0 && dac_q == '0, "R1 registers", dac_q[63:0], 0);

    // R2 / R3 write then update
    step(1'b1, 4'd0, 4'd2, 16'hA5A5, 1'b0);
    chk(dac_q[2*DW +: DW] == '0, "R2 DAC untouched by write", dac_q[2*DW +: DW], 0);
    step(1'b1, 4'd1, 4'd2, 16'h0000, 1'b0);
    chk(dac_q[2*DW +: DW] == 16'hA5A5, "R3 update copy", dac_q[2*DW +: DW], 16'hA5A5);

    // R5 single channel down, data ignored
    step(1'b1, 4'd4, 4'd2, 16'hFFFF, 1'b0);
    chk(ch_pwr_en == 8'hFB && inp_q[2*DW +: DW] == 16'hA5A5, "R5 channel down",
        ch_pwr_en, 8'hFB);
    // R10 short window
    step(1'b1, 4'd3, 4'd2, 16'h1234, 1'b0);
    busy_len(n);
    chk(n == SHORT, "R10 short settle", n, SHORT);

    // R8 external lock across chip shutdown and wake
    step(1'b1, 4'd7, 4'd0, 16'h0, 1'b0);
    chk(!ref_int_en && ref_ext_sel, "R8 external select", ref_int_en, 0);
    step(1'b1, 4'd5, 4'd0, 16'hBEEF, 1'b0);
    chk(ch_pwr_en == '0 && ref_hiz, "R6 chip down", {ch_pwr_en, ref_hiz}, 9'h001);
    chk(ref_hiz, "R11 hiz", ref_hiz, 1);
    step(1'b1, 4'd3, 4'd0, 16'h0777, 1'b0);
    chk(!ref_int_en && ch_pwr_en == 8'h01, "R8 ref stays off", ref_int_en, 0);
    busy_len(n);
    chk(n == LONG, "R10 long settle", n, LONG);
    step(1'b1, 4'd6, 4'd0, 16'h0, 1'b0);
    chk(ref_int_en && !ref_ext_sel, "R8 internal restore", ref_int_en, 1);

    // R9 / R4 chip shutdown recovered by load pulse
    step(1'b1, 4'd0, 4'd5, 16'h5555, 1'b0);
    step(1'b1, 4'd5, 4'd0, 16'h0, 1'b0);
    step(1'b0, 4'd0, 4'd0, 16'h0, 1'b1);
    chk(ref_int_en && ch_pwr_en == '1, "R9 ref back on wake", ref_int_en, 1);
    chk(dac_q[5*DW +: DW] == 16'h5555, "R4 load copies", dac_q[5*DW +: DW], 16'h5555);
    busy_len(n);
    chk(n == LONG, "R10 long after chip down", n, LONG);

    // R7 power-up beats power-down in one cycle
    step(1'b1, 4'd4, 4'hF, 16'h0, 1'b1);
    chk(ch_pwr_en == '1, "R7 update priority", ch_pwr_en, 8'hFF);

    // random phase
    r = $urandom(32'h00C0FFEE);
    for (int k = 0; k < 4000; k++) begin
      logic [3:0] c, a;
      logic v, l;
      r = $urandom;
      v = (r[3:0] != 4'd0);
      c = (r[7:4] == 4'hF) ? 4'(r[11:8] | 4'h8) : 4'(r[6:4]);
      a = r[12] ? 4'hF : 4'(r[15:13]);
      if (r[16] && r[17]) a = 4'hA;
      l = (r[21:18] == 4'd0);
      step(v, c, a, 16'($urandom), l);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule